// File: doc/BRIEF.md
# Operating Mode Control Register

This block is a single memory-mapped control byte for a small 8-bit microcontroller. While reset is held, it samples two mode-select pins. The value present when reset is released fixes the operating mode: normal single-chip, normal expanded, special bootstrap or special test. After that, software can change only a limited set of bits, and the rules depend on whether the special-mode bit is still set. The bits that leave the chip are the mode pair, a bootstrap-ROM map enable with its address-window select, an internal-read-visibility control and an E-clock suppress control. A 4-bit priority field is plain storage.

The register sits on a simple synchronous CPU bus with an address, write data, a read strobe and a write strobe. A read returns the register combinationally in the same cycle. A write takes effect at the clock edge that samples the write strobe. The bus has no data stream and no back-pressure. Every pin is a plain level that is sampled or driven each cycle, so no valid/ready handshake applies.

Top module: `mode_ctl_reg`

## Requirements
- R1: The register sits at address 0x003C with the layout bit 7 boot map, bit 6 special, bit 5 expand, bit 4 visibility, bits 3..0 priority. On the first cycle after reset is released, special equals the inverse of `mode_sel_b_i`, expand equals `mode_sel_a_i`, boot map equals special, visibility is 1 only when both special and expand are 1, and priority is 0101.
- R2: When `rd_en_i` is high and `addr_i` is 0x003C, `rdata_o` shows the register value in that same cycle. In every other case `rdata_o` is 0x00.
- R3: A write can clear the special bit. It can never set it.
- R4: A write changes the expand bit only if the special bit was 1 before that write. If the special bit was 0, the expand bit holds its value.
- R5: The boot map bit follows write data only while the special bit stays 1. It reads 0 whenever special is 0, and a write that clears special also clears it.
- R6: `boot_rom_sel_o` is high exactly when the boot map bit is 1 and `addr_i` is in 0xBF40..0xBFFF. It does not depend on the strobes.
- R7: `mode_o` equals {special, expand}, where 00 is normal single-chip, 01 normal expanded, 10 special bootstrap and 11 special test. `special_o` and `expanded_o` mirror the two bits.
- R8: `e_clk_low_o` is high exactly when visibility is 1 and expand is 0 (single-chip modes).
- R9: `int_rd_drive_o` is high exactly when `rd_en_i` is high, the address is internal, expand is 1 and visibility is 1. Internal addresses are 0x0000..0x00FF, 0xF000..0xFFFF, and 0xBF40..0xBFFF while boot map is 1.
- R10: The visibility bit and the priority field take write data in every mode. A write appears on the read port from the cycle after the write strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; mode pins are captured while low |
| mode_sel_a_i | input | 1 | Mode-select pin A (level becomes expand bit) |
| mode_sel_b_i | input | 1 | Mode-select pin B (inverse becomes special bit) |
| addr_i | input | 16 | CPU bus address |
| wdata_i | input | 8 | CPU write data |
| rd_en_i | input | 1 | Read strobe |
| wr_en_i | input | 1 | Write strobe |
| rdata_o | output | 8 | Read data, zero when not selected |
| mode_o | output | 2 | Operating mode {special, expand} |
| special_o | output | 1 | Special-mode variation active |
| expanded_o | output | 1 | Expanded or test mode active |
| boot_map_o | output | 1 | Bootstrap ROM mapped in |
| boot_rom_sel_o | output | 1 | Address falls in the mapped bootstrap ROM window |
| e_clk_low_o | output | 1 | Hold E pin low instead of driving the clock |
| int_rd_drive_o | output | 1 | Drive internal read data onto the external bus |

## Verification
Assertions check several rules on every cycle after reset. The special bit never rises. The expand bit holds while special is clear, and boot map is never set without special. The ROM select, E suppress and drive-out outputs never assert outside their enabling conditions. Some behaviour can only be shown by the bench scenarios: the exact bit values captured for each of the four pin combinations, the window edges 0xBF3F/0xBF40/0xBFFF/0xC000, the masking of a full-byte write in each mode, and the same-write case where clearing special still lets expand be written. The bench covers these with chosen sequences of resets, writes and reads.

// File: rtl/mode_ctl_pkg.sv
package mode_ctl_pkg;

  localparam int PRIO_W = 4;

  typedef enum logic [1:0] {
    MODE_SINGLE = 2'b00,
    MODE_EXPAND = 2'b01,
    MODE_BOOT   = 2'b10,
    MODE_TEST   = 2'b11
  } op_mode_e;

  // Field order is the bus layout: boot map in the MSB, priority in the LSBs.
  typedef struct packed {
    logic              boot;
    logic              spec;
    logic              expand;
    logic              vis;
    logic [PRIO_W-1:0] prio;
  } ctl_reg_t;

  localparam int REG_W = $bits(ctl_reg_t);

  function automatic ctl_reg_t reset_image(input logic pin_a, input logic pin_b,
                                           input logic [PRIO_W-1:0] prio_rst);
    ctl_reg_t r;
    r.spec   = ~pin_b;
    r.expand = pin_a;
    r.boot   = ~pin_b;
    r.vis    = ~pin_b & pin_a;
    r.prio   = prio_rst;
    return r;
  endfunction

endpackage

// File: rtl/mode_ctl_capture.sv
module mode_ctl_capture
  import mode_ctl_pkg::*;
#(
  parameter logic [PRIO_W-1:0] PRIO_RST = 4'b0101
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pin_a,
  input  logic             pin_b,
  input  logic             wr_hit,
  input  logic [REG_W-1:0] wdata,
  output ctl_reg_t         q
);

  ctl_reg_t wr_img;
  ctl_reg_t nxt;

  assign wr_img = ctl_reg_t'(wdata);

  always_comb begin
    nxt = q;
    if (wr_hit) begin
      // special can only fall
      nxt.spec   = q.spec & wr_img.spec;
      // expand is open only while special was set before the write
      nxt.expand = q.spec ? wr_img.expand : q.expand;
      // boot map survives only while special stays set
      nxt.boot   = nxt.spec & wr_img.boot;
      nxt.vis    = wr_img.vis;
      nxt.prio   = wr_img.prio;
    end
  end

  // Pins are sampled on every clock while reset is low; the last sample stays.
  always_ff @(posedge clk) begin
    if (!rst_n) q <= reset_image(pin_a, pin_b, PRIO_RST);
    else        q <= nxt;
  end

  p_spec_never_rises_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> !$rose(q.spec));

  p_expand_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(q.spec)) |-> $stable(q.expand));

  p_boot_needs_spec_r5: assert property (@(posedge clk) disable iff (!rst_n)
    q.boot |-> q.spec);

  p_write_lands_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> (q.prio == $past(wdata[PRIO_W-1:0])) && (q.vis == $past(wdata[PRIO_W])));

endmodule

// File: rtl/mode_ctl_addr_dec.sv
module mode_ctl_addr_dec #(
  parameter int                           ADDR_W   = 16,
  parameter logic [ADDR_W-1:0]            REG_ADDR = 16'h003C,
  parameter logic [ADDR_W-1:0]            BOOT_LO  = 16'hBF40,
  parameter logic [ADDR_W-1:0]            BOOT_HI  = 16'hBFFF,
  parameter int                           N_INT    = 2,
  parameter logic [N_INT-1:0][ADDR_W-1:0] INT_LO   = {16'hF000, 16'h0000},
  parameter logic [N_INT-1:0][ADDR_W-1:0] INT_HI   = {16'hFFFF, 16'h00FF}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              boot_en,
  output logic              reg_hit,
  output logic              boot_sel,
  output logic              int_hit
);

  logic [N_INT-1:0] region_hit;
  logic             boot_win;

  for (genvar g = 0; g < N_INT; g++) begin : g_region
    assign region_hit[g] = (addr >= INT_LO[g]) && (addr <= INT_HI[g]);
  end

  assign reg_hit  = (addr == REG_ADDR);
  assign boot_win = (addr >= BOOT_LO) && (addr <= BOOT_HI);
  assign boot_sel = boot_win & boot_en;
  assign int_hit  = (|region_hit) | boot_sel;

  p_rom_sel_needs_map_r6: assert property (@(posedge clk) disable iff (!rst_n)
    boot_sel |-> boot_en);

  p_rom_sel_is_internal_r9: assert property (@(posedge clk) disable iff (!rst_n)
    boot_sel |-> int_hit);

endmodule

// File: rtl/mode_ctl_out.sv
module mode_ctl_out
  import mode_ctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  ctl_reg_t   q,
  input  logic       rd_en,
  input  logic       int_hit,
  output logic [1:0] mode,
  output logic       special,
  output logic       expanded,
  output logic       boot_map,
  output logic       e_clk_low,
  output logic       int_rd_drive
);

  op_mode_e m;

  assign m            = op_mode_e'({q.spec, q.expand});
  assign mode         = m;
  assign special      = q.spec;
  assign expanded     = q.expand;
  assign boot_map     = q.boot;
  assign e_clk_low    = q.vis && (m == MODE_SINGLE || m == MODE_BOOT);
  assign int_rd_drive = rd_en && int_hit && q.vis && (m == MODE_EXPAND || m == MODE_TEST);

  p_eclk_single_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    e_clk_low |-> !expanded);

  p_drive_needs_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    int_rd_drive |-> (rd_en && expanded && !e_clk_low));

  p_drive_eclk_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({int_rd_drive, e_clk_low}) <= 1);

endmodule

// File: rtl/mode_ctl_reg.sv
module mode_ctl_reg
  import mode_ctl_pkg::*;
#(
  parameter int                ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] REG_ADDR = 16'h003C,
  parameter logic [ADDR_W-1:0] BOOT_LO  = 16'hBF40,
  parameter logic [ADDR_W-1:0] BOOT_HI  = 16'hBFFF,
  parameter logic [PRIO_W-1:0] PRIO_RST = 4'b0101
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_sel_a_i,
  input  logic              mode_sel_b_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic              rd_en_i,
  input  logic              wr_en_i,
  output logic [REG_W-1:0]  rdata_o,
  output logic [1:0]        mode_o,
  output logic              special_o,
  output logic              expanded_o,
  output logic              boot_map_o,
  output logic              boot_rom_sel_o,
  output logic              e_clk_low_o,
  output logic              int_rd_drive_o
);

  ctl_reg_t q;
  logic     reg_hit;
  logic     int_hit;

  mode_ctl_addr_dec #(
    .ADDR_W  (ADDR_W),
    .REG_ADDR(REG_ADDR),
    .BOOT_LO (BOOT_LO),
    .BOOT_HI (BOOT_HI)
  ) u_dec (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr    (addr_i),
    .boot_en (q.boot),
    .reg_hit (reg_hit),
    .boot_sel(boot_rom_sel_o),
    .int_hit (int_hit)
  );

  mode_ctl_capture #(
    .PRIO_RST(PRIO_RST)
  ) u_cap (
    .clk   (clk),
    .rst_n (rst_n),
    .pin_a (mode_sel_a_i),
    .pin_b (mode_sel_b_i),
    .wr_hit(wr_en_i && reg_hit),
    .wdata (wdata_i),
    .q     (q)
  );

  mode_ctl_out u_out (
    .clk         (clk),
    .rst_n       (rst_n),
    .q           (q),
    .rd_en       (rd_en_i),
    .int_hit     (int_hit),
    .mode        (mode_o),
    .special     (special_o),
    .expanded    (expanded_o),
    .boot_map    (boot_map_o),
    .e_clk_low   (e_clk_low_o),
    .int_rd_drive(int_rd_drive_o)
  );

  assign rdata_o = (rd_en_i && reg_hit) ? REG_W'(q) : '0;

  p_rdata_idle_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |-> (rdata_o == '0));

endmodule

// File: tb/mode_ctl_reg_bench.sv
module mode_ctl_reg_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pa = 1'b0, pb = 1'b1;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        rd_en = 1'b0, wr_en = 1'b0;
  logic [7:0]  rdata;
  logic [1:0]  mode;
  logic        special, expanded, boot_map, rom_sel, e_low, drive;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [7:0] exp_data_q[$];
  logic       exp_drv_q[$];
  string      exp_tag_q[$];

  always #4 clk = ~clk;

  mode_ctl_reg u_mode_ctl_reg (
    .clk(clk), .rst_n(rst_n), .mode_sel_a_i(pa), .mode_sel_b_i(pb),
    .addr_i(addr), .wdata_i(wdata), .rd_en_i(rd_en), .wr_en_i(wr_en),
    .rdata_o(rdata), .mode_o(mode), .special_o(special), .expanded_o(expanded),
    .boot_map_o(boot_map), .boot_rom_sel_o(rom_sel), .e_clk_low_o(e_low),
    .int_rd_drive_o(drive)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic a, input logic b);
    @(posedge clk); #1;
    rst_n = 1'b0; pa = a; pb = b; rd_en = 0; wr_en = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  // driver: pushes expectations, monitor compares in the low phase
  task automatic rd(input logic [15:0] a, input logic [7:0] exp, input logic exp_drv,
                    input string tag);
    @(posedge clk); #1;
    addr = a; rd_en = 1'b1;
    exp_data_q.push_back(exp);
    exp_drv_q.push_back(exp_drv);
    exp_tag_q.push_back(tag);
    @(posedge clk); #1;
    rd_en = 1'b0;
  endtask

  task automatic probe(input logic [15:0] a);
    @(posedge clk); #1;
    addr = a;
    #2;
  endtask

  always @(negedge clk) begin
    if (rd_en && rst_n) begin
      if (exp_data_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R2: read with no expectation, actual %h expected none", rdata);
      end else begin
        string t;
        t = exp_tag_q.pop_front();
        chk({t, " rdata"}, 16'(rdata), 16'(exp_data_q.pop_front()));
        chk({t, " drive R9"}, 16'(drive), 16'(exp_drv_q.pop_front()));
      end
    end
  end

  initial begin
    // normal single-chip: B high, A low
    do_reset(1'b0, 1'b1);
    #2;
    chk("R1 single mode", 16'(mode), 16'b00);
    chk("R7 special_o", 16'(special), 16'd0);
    rd(16'h003C, 8'h05, 1'b0, "R1 single image");
    wr(16'h003C, 8'hFF);
    rd(16'h003C, 8'h1F, 1'b0, "R3 R4 R5 R10 masked write");
    #2;
    chk("R8 E low in single", 16'(e_low), 16'd1);
    probe(16'hBF40);
    chk("R6 no rom sel unmapped", 16'(rom_sel), 16'd0);
    rd(16'h0040, 8'h00, 1'b0, "R9 no drive single-chip");
    @(posedge clk); #1 addr = 16'h003C; #2;
    chk("R2 rdata zero without strobe", 16'(rdata), 16'h00);

    // special bootstrap: both low
    do_reset(1'b0, 1'b0);
    #2;
    chk("R7 boot mode", 16'(mode), 16'b10);
    chk("R1 boot_map_o", 16'(boot_map), 16'd1);
    rd(16'h003C, 8'hC5, 1'b0, "R1 boot image");
    probe(16'hBF3F); chk("R6 below window", 16'(rom_sel), 16'd0);
    probe(16'hBF40); chk("R6 window low edge", 16'(rom_sel), 16'd1);
    probe(16'hBFFF); chk("R6 window high edge", 16'(rom_sel), 16'd1);
    probe(16'hC000); chk("R6 above window", 16'(rom_sel), 16'd0);
    wr(16'h003C, 8'hE5);
    rd(16'h003C, 8'hE5, 1'b0, "R4 expand writable in special");
    #2 chk("R7 test via write", 16'(mode), 16'b11);
    wr(16'h003C, 8'hB5);
    rd(16'h003C, 8'h35, 1'b1, "R3 R5 clear special drops boot");
    #2 chk("R7 expanded after clear", 16'(mode), 16'b01);
    wr(16'h003C, 8'hC0);
    rd(16'h003C, 8'h20, 1'b0, "R4 expand locked R3 no set");
    wr(16'h003C, 8'h10);
    rd(16'h0050, 8'h00, 1'b1, "R9 RAM read driven");
    rd(16'h2000, 8'h00, 1'b0, "R9 external not driven");
    rd(16'hBF50, 8'h00, 1'b0, "R9 unmapped window external");
    rd(16'hF123, 8'h00, 1'b1, "R9 ROM read driven");
    #2 chk("R8 no E low expanded", 16'(e_low), 16'd0);

    // special test: B low, A high
    do_reset(1'b1, 1'b0);
    rd(16'h003C, 8'hF5, 1'b1, "R1 test image");
    rd(16'hBF80, 8'h00, 1'b1, "R9 mapped window internal");
    probe(16'hBF80); chk("R6 rom sel no strobe", 16'(rom_sel), 16'd1);

    // normal expanded: both high
    do_reset(1'b1, 1'b1);
    rd(16'h003C, 8'h25, 1'b0, "R1 expanded image");
    wr(16'h003C, 8'h40);
    rd(16'h003C, 8'h20, 1'b0, "R3 R4 no set, expand kept");
    #2 chk("R7 expanded_o", 16'(expanded), 16'd1);

    repeat (2) @(posedge clk);
    chk("R2 scoreboard drained", 16'(exp_data_q.size()), 16'd0);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule